// File: doc/BRIEF.md
# Immediate Byte Substitution Unit

This unit sits between instruction fetch and execute. Fetch hands it the three immediate bytes that follow an opcode byte. It returns those bytes unchanged, or it returns some of them with values taken from the register file. Swapping in register values lets a program build pointers or branch targets at run time, which a fixed immediate field cannot express.

Substitution values are staged by a short run of prefix instructions. The prefix for lane 0 stores one register-file byte for the lowest immediate byte and starts a new run. The prefix for lane 1 then stages the middle byte, and the prefix for lane 2 stages the top byte. The first non-prefix instruction that retires after the run is the only one that sees the staged bytes. Once it retires, the unit becomes transparent again.

State changes only on cycles where the instruction-advance strobe is high. On any other cycle the inputs are held and nothing changes.

Top module: `imo_unit`

## Requirements
- R1: After synchronous reset, no lane is staged, and `imm_o` equals `imm_raw_i` on every byte.
- R2: When no lane is staged, `imm_o` equals `imm_raw_i` in the same cycle, whatever its value.
- R3: The control code values are: 0 means a non-prefix instruction, and k+1 means the prefix for byte lane k, where lane 0 is bits 7:0. With `adv_i` high, code 1 stores `reg_data_i` for lane 0. From the next cycle, `imm_o[7:0]` shows the stored byte.
- R4: Prefixes must come in order. With `adv_i` high, code 2 stages lane 1 only if lane 0 is already staged. Code 3 stages lane 2 only if lane 1 is already staged. A prefix that arrives out of order is ignored, and the output stays as it was.
- R5: A lane-0 prefix starts a new run: it discards any staged value in lanes 1 and 2.
- R6: A lane that has not been staged in the current run passes its raw byte through, even when other lanes are substituted.
- R7: A code-0 instruction retiring with `adv_i` high clears all staged lanes. From the next cycle the unit is transparent again.
- R8: While `adv_i` is low, no code or data changes the staged state.
- R9: A prefix instruction does not consume staged lanes. Lanes staged earlier in the run stay in force through the later prefixes of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Current instruction retires this cycle |
| ci_code_i | input | 2 | Control code of the current instruction (0 = non-prefix, k+1 = lane-k prefix) |
| reg_data_i | input | 8 | Register-file operand byte |
| imm_raw_i | input | 24 | Immediate bytes from fetch, lane 0 in bits 7:0 |
| imm_o | output | 24 | Immediate bytes delivered to execute |

## Verification
Staging and clearing take effect on the clock edge where `adv_i` is sampled high. The substituted or raw byte therefore shows on `imm_o` from the very next cycle. The output mux is combinational, so a change on `imm_raw_i` shows without delay. The bench drives each instruction half a cycle before the edge that takes it. After that edge it applies a fresh raw pattern and samples `imm_o` one time unit later, so every check reads exactly one edge of state. Stall checks hold `adv_i` low across an edge and then confirm that the output is unchanged.

// File: rtl/imo_pkg.sv
package imo_pkg;

    // Per-lane control produced by the sequencer
    typedef struct packed {
        logic load;
        logic clear;
    } lane_ctl_t;

    // Control code that stages lane k
    function automatic int unsigned lane_code(input int unsigned k);
        return k + 1;
    endfunction

endpackage

// File: rtl/imo_lane.sv
module imo_lane
    import imo_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_ctl_t         ctl_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic [BYTE_W-1:0] raw_i,
    output logic [BYTE_W-1:0] out_o,
    output logic              vld_o
);

    logic [BYTE_W-1:0] held_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            vld_q  <= 1'b0;
        end else if (ctl_i.load) begin
            held_q <= din_i;
            vld_q  <= 1'b1;
        end else if (ctl_i.clear) begin
            vld_q  <= 1'b0;
        end
    end

    assign out_o = vld_q ? held_q : raw_i;
    assign vld_o = vld_q;

    // R3: a load becomes visible on the output from the next cycle
    a_r3_load_visible: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> (vld_o && out_o == $past(din_i)));

    // R8: with no command, the stored state is unchanged
    a_r8_hold_state: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.load && !ctl_i.clear) |=> ($stable(vld_q) && $stable(held_q)));

endmodule

// File: rtl/imo_seq.sv
module imo_seq
    import imo_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int CODE_W = 2
) (
    input  logic                  adv_i,
    input  logic [CODE_W-1:0]     code_i,
    input  logic [LANES-1:0]      vld_i,
    output lane_ctl_t [LANES-1:0] ctl_o
);

    logic is_plain;
    logic is_restart;

    assign is_plain   = adv_i && (code_i == '0);
    assign is_restart = adv_i && (code_i == CODE_W'(lane_code(0)));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic hit;
        logic order_ok;

        assign hit = adv_i && (code_i == CODE_W'(lane_code(k)));

        if (k == 0) begin : g_first
            assign order_ok = 1'b1;
            assign ctl_o[k].clear = is_plain;
        end else begin : g_next
            assign order_ok = vld_i[k-1];
            assign ctl_o[k].clear = is_plain || is_restart;
        end

        assign ctl_o[k].load = hit && order_ok;
    end

endmodule

// File: rtl/imo_unit.sv
module imo_unit
    import imo_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 3,
    parameter int CODE_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv_i,
    input  logic [CODE_W-1:0]       ci_code_i,
    input  logic [BYTE_W-1:0]       reg_data_i,
    input  logic [LANES*BYTE_W-1:0] imm_raw_i,
    output logic [LANES*BYTE_W-1:0] imm_o
);

    lane_ctl_t [LANES-1:0] lane_ctl;
    logic      [LANES-1:0] lane_vld;

    imo_seq #(
        .LANES (LANES),
        .CODE_W(CODE_W)
    ) u_seq (
        .adv_i (adv_i),
        .code_i(ci_code_i),
        .vld_i (lane_vld),
        .ctl_o (lane_ctl)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        imo_lane #(
            .BYTE_W(BYTE_W)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .ctl_i(lane_ctl[k]),
            .din_i(reg_data_i),
            .raw_i(imm_raw_i[k*BYTE_W +: BYTE_W]),
            .out_o(imm_o[k*BYTE_W +: BYTE_W]),
            .vld_o(lane_vld[k])
        );
    end

    // R2: with nothing staged, the output equals the raw input
    a_r2_transparent: assert property (@(posedge clk) disable iff (rst)
        (lane_vld == '0) |-> (imm_o == imm_raw_i));

    // R7: a retiring non-prefix instruction leaves nothing staged
    a_r7_consume: assert property (@(posedge clk) disable iff (rst)
        (adv_i && ci_code_i == '0) |=> (lane_vld == '0));

    // R5: a lane-0 prefix leaves only lane 0 staged
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (adv_i && ci_code_i == CODE_W'(1)) |=> (lane_vld == LANES'(1)));

    // R4: a lane-1 prefix without lane 0 staged does not stage lane 1
    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        (adv_i && ci_code_i == CODE_W'(2) && !lane_vld[0])
            |=> (lane_vld[1] == $past(lane_vld[1])));

    // R8: state holds while the advance strobe is low
    a_r8_stall: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(lane_vld));

    // R9: a prefix never clears lane 0
    a_r9_keep: assert property (@(posedge clk) disable iff (rst)
        (adv_i && ci_code_i != '0 && lane_vld[0]) |=> lane_vld[0]);

endmodule

// File: tb/imo_unit_bench.sv
module imo_unit_bench;

    localparam int PERIOD = 10;
    localparam int BW     = 8;
    localparam int NL     = 3;
    localparam int CW     = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            adv = 1'b0;
    logic [CW-1:0]   code = '0;
    logic [BW-1:0]   rdata = '0;
    logic [NL*BW-1:0] raw = '0;
    logic [NL*BW-1:0] imm;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // independent expectation state
    bit        mv [NL];
    logic [BW-1:0] md [NL];

    imo_unit u_imo_unit (
        .clk       (clk),
        .rst       (rst),
        .adv_i     (adv),
        .ci_code_i (code),
        .reg_data_i(rdata),
        .imm_raw_i (raw),
        .imm_o     (imm)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [NL*BW-1:0] act,
                         input logic [NL*BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NL*BW-1:0] expect_out(input logic [NL*BW-1:0] r);
        logic [NL*BW-1:0] e;
        for (int k = 0; k < NL; k++)
            e[k*BW +: BW] = mv[k] ? md[k] : r[k*BW +: BW];
        return e;
    endfunction

    // apply the rules to the expectation state for one retiring instruction
    task automatic model_step(input int c, input logic [BW-1:0] d);
        if (c == 0) begin
            for (int k = 0; k < NL; k++) mv[k] = 1'b0;
        end else if (c == 1) begin
            mv[0] = 1'b1; md[0] = d;
            for (int k = 1; k < NL; k++) mv[k] = 1'b0;
        end else if (mv[c-2]) begin
            mv[c-1] = 1'b1; md[c-1] = d;
        end
    endtask

    // drive one instruction, let one edge pass, then check with a new raw pattern
    task automatic issue(input int c, input logic [BW-1:0] d, input bit a,
                         input logic [NL*BW-1:0] newraw, input string tag);
        @(negedge clk);
        code  = CW'(c);
        rdata = d;
        adv   = a;
        if (a) model_step(c, d);
        @(negedge clk);
        adv = 1'b0;
        raw = newraw;
        #1;
        check(tag, imm, expect_out(newraw));
    endtask

    initial begin
        for (int k = 0; k < NL; k++) begin mv[k] = 1'b0; md[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        raw = 24'hA5C3_5A;
        #1;
        check("R1", imm, 24'hA5C35A);
        raw = 24'h123456;
        #1;
        check("R2", imm, 24'h123456);

        // exhaustive sweep over all three-code runs, then a consuming instruction
        for (int a0 = 0; a0 < 4; a0++)
            for (int a1 = 0; a1 < 4; a1++)
                for (int a2 = 0; a2 < 4; a2++) begin
                    int seq = a0*16 + a1*4 + a2;
                    issue(a0, BW'(8'h10 + seq), 1'b1, {BW'(seq), BW'(seq ^ 8'hFF), BW'(seq + 3)}, "R4");
                    issue(a1, BW'(8'h50 + seq), 1'b1, {BW'(seq * 3), BW'(seq + 7), BW'(~seq)}, "R9");
                    issue(a2, BW'(8'h90 + seq), 1'b1, {BW'(seq + 1), BW'(seq * 5), BW'(seq ^ 8'h3C)}, "R6");
                    issue(0, 8'hEE, 1'b1, {BW'(seq + 9), BW'(seq), BW'(seq * 7)}, "R7");
                end

        // full ordered run, checked byte by byte
        issue(1, 8'hC1, 1'b1, 24'h000000, "R3");
        check("R3", {16'h0000, imm[7:0]}, 24'h0000C1);
        issue(2, 8'hC2, 1'b1, 24'hFFFFFF, "R6");
        issue(3, 8'hC3, 1'b1, 24'h777777, "R9");
        check("R9", imm, 24'hC3C2C1);
        // R5: a restart drops lanes 1 and 2
        issue(1, 8'h44, 1'b1, 24'hABCDEF, "R5");
        check("R5", imm, 24'hABCD44);
        // R8: stalled prefixes and stalled consumers change nothing
        issue(2, 8'h99, 1'b0, 24'h010203, "R8");
        check("R8", imm, 24'h010244);
        issue(0, 8'h00, 1'b0, 24'h0A0B0C, "R8");
        check("R8", imm, 24'h0A0B44);
        issue(0, 8'h00, 1'b1, 24'h0D0E0F, "R7");
        check("R7", imm, 24'h0D0E0F);
        // R4: a lane-2 prefix without lane 1 is ignored
        issue(3, 8'h5F, 1'b1, 24'h112233, "R4");
        check("R4", imm, 24'h112233);

        // R1: reset in mid-run makes the unit transparent
        issue(1, 8'h66, 1'b1, 24'h445566, "R3");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < NL; k++) mv[k] = 1'b0;
        raw = 24'h9A8B7C;
        #1;
        check("R1", imm, 24'h9A8B7C);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule